// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block catches a processor that has stopped servicing it. Software writes an 8-bit setting over a plain write strobe. The setting holds a steering bit, a 5-bit multiplier and a 2-bit resolution code. The block counts resolution ticks. When the multiplier's worth of ticks has gone by without a fresh write, it raises a watchdog flag.

Depending on the steering bit, the timeout does one of two things. With steering clear, it holds an interrupt request until software acknowledges the flag. With steering set, it drops an active-low reset output for a fixed number of base clock cycles. In that case it also wipes the setting, and emits a one-cycle strobe that tells neighbouring logic to clear its test-mode and alarm-enable bits.

Resolution ticks come from a free-running prescaler fed by a 16 Hz strobe. A write does not realign the prescaler, so a period may end up to one resolution step early.

Top module: `wdt_steer`

## Requirements
- R1: After `rst_n` deasserts, `cfg_o` is 8'h00, `wd_flag_o` and `irq_o` are 0, `aux_clr_o` is 0 and `rst_n_o` is 1.
- R2: A write with `pwr_fail_i` low stores `wr_data_i` into `cfg_o` on that clock edge. The fields are: bit 7 steering, bits 6:2 multiplier M, bits 1:0 resolution code.
- R3: Resolution code 00 counts every `tick16_i` strobe. Code 01 counts only strobes whose ordinal since reset (the first is 1) is a multiple of 4. Code 10 uses multiples of 16, and code 11 uses multiples of 64. `wd_flag_o` rises on the clock edge that samples the M-th counted strobe after the last write.
- R4: Any write restarts the count from zero, including a write of the same value.
- R5: A setting of 8'h00, or any setting with M = 0, never produces a timeout.
- R6: A timeout with steering 0 sets `wd_flag_o` and `irq_o`. The setting stays unchanged and `rst_n_o` stays 1.
- R7: A timeout with steering 1 does four things on the same edge. It sets `wd_flag_o`, clears `cfg_o` to 0, and pulses `aux_clr_o` high for exactly one cycle. It also drives `rst_n_o` low for exactly RST_CYC clock cycles.
- R8: While `pwr_fail_i` is high, the setting is held at 0 and writes are ignored, so no timeout follows.
- R9: A `flag_clr_i` strobe clears `wd_flag_o` and `irq_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | One-cycle 16 Hz timebase strobe |
| pwr_fail_i | input | 1 | Power-down indication; clears and locks the setting |
| wr_en_i | input | 1 | Setting write strobe |
| wr_data_i | input | 8 | Setting value to write |
| flag_clr_i | input | 1 | Flag acknowledge (read of the flag register) |
| cfg_o | output | 8 | Current setting |
| wd_flag_o | output | 1 | Watchdog timeout flag |
| irq_o | output | 1 | Interrupt request, active high |
| rst_n_o | output | 1 | Reset pulse, active low |
| aux_clr_o | output | 1 | One-cycle strobe to clear neighbouring control bits |

## Verification
The hardest cases to reach are the coarse resolutions. Their ticks depend on a prescaler phase that no write resets, so the moment a timeout lands depends on the whole strobe history since reset. The bench drives every 16 Hz strobe itself and keeps its own ordinal count. From that count it predicts the exact strobe that must raise the flag, and queues the prediction for the monitor. The reset-steered case is reached the same way, and the bench then counts the width of the low pulse cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MUL_W = 5;
  localparam int RES_W = 2;
  localparam int CFG_W = 1 + MUL_W + RES_W;

  typedef struct packed {
    logic             steer;
    logic [MUL_W-1:0] mult;
    logic [RES_W-1:0] res;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int STAGES  = 3,
  parameter int DIV_LOG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  output logic [STAGES:0] tap_o
);
  localparam int CW = STAGES * DIV_LOG;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tap_o[0] = tick_i;
  for (genvar g = 1; g <= STAGES; g++) begin : g_tap
    assign tap_o[g] = tick_i & (&cnt_q[g*DIV_LOG-1:0]);
  end

  // coarser taps are always a subset of finer ones (R3)
  p_tap_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tap_o[STAGES] |-> tap_o[0]);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int MUL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [MUL_W-1:0] mult_i,
  output logic             to_o
);
  logic [MUL_W-1:0] cnt_q;
  logic [MUL_W-1:0] nxt;

  assign nxt  = cnt_q + 1'b1;
  assign to_o = en_i & tick_i & (nxt == mult_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i || to_o)   cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= nxt;
  end

  // after a write the count starts from zero (R4)
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // no timeout when disabled (R5)
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_i == '0) |-> !to_o);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic rst_n_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign rst_n_o = (cnt_q == '0);

  // the pulse begins on the edge after a reset-steered timeout (R7)
  p_pulse_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !rst_n_o);
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_pkg::*;
#(
  parameter int RST_CYC = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16_i,
  input  logic             pwr_fail_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             wd_flag_o,
  output logic             irq_o,
  output logic             rst_n_o,
  output logic             aux_clr_o
);
  localparam int NRES = 1 << RES_W;

  wdt_cfg_t        cfg_q;
  logic [NRES-1:0] tap;
  logic            sel_tick;
  logic            en;
  logic            wr_fire;
  logic            timeout;
  logic            flag_q, irq_q, aux_q;

  assign wr_fire  = wr_en_i & ~pwr_fail_i;
  assign en       = (cfg_q.mult != '0) & ~pwr_fail_i;
  assign sel_tick = tap[cfg_q.res];

  wdt_prescaler #(.STAGES(NRES-1), .DIV_LOG(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick16_i), .tap_o(tap)
  );

  wdt_counter #(.MUL_W(MUL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(wr_fire | ~en), .en_i(en),
    .tick_i(sel_tick), .mult_i(cfg_q.mult), .to_o(timeout)
  );

  wdt_pulse #(.LEN(RST_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start_i(timeout & cfg_q.steer),
    .rst_n_o(rst_n_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      if (pwr_fail_i)                  cfg_q <= '0;
      else if (timeout && cfg_q.steer) cfg_q <= '0;
      else if (wr_fire)                cfg_q <= wdt_cfg_t'(wr_data_i);

      if (timeout)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;

      if (timeout && !cfg_q.steer) irq_q <= 1'b1;
      else if (flag_clr_i)         irq_q <= 1'b0;

      aux_q <= timeout & cfg_q.steer;
    end
  end

  assign cfg_o     = cfg_q;
  assign wd_flag_o = flag_q;
  assign irq_o     = irq_q;
  assign aux_clr_o = aux_q;

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> wd_flag_o);
  p_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && cfg_q.steer) |=> (cfg_o == '0) && aux_clr_o && !rst_n_o);
  p_pwr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> (cfg_o == '0));
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !timeout) |=> !wd_flag_o && !irq_o);
endmodule

// File: tb/wdt_steer_tb.sv
module wdt_steer_tb;
  localparam int RST_CYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0, pwr_fail = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] cfg;
  logic       flag, irq, rst_out, aux;

  int checks = 0;
  int errors = 0;
  int tick_n = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  wdt_steer #(.RST_CYC(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .pwr_fail_i(pwr_fail),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .flag_clr_i(flag_clr),
    .cfg_o(cfg), .wd_flag_o(flag), .irq_o(irq), .rst_n_o(rst_out),
    .aux_clr_o(aux)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick16 = 1'b1; tick_n++;
    @(negedge clk); tick16 = 1'b0;
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // expected ordinal of the flag-raising strobe, pushed to the scoreboard
  function automatic int predict(int m, int code);
    int d = 1 << (2 * code);
    return ((tick_n / d) + 1) * d + (m - 1) * d;
  endfunction

  task automatic arm(int steer, int m, int code, output int ord);
    wr(8'((steer << 7) | (m << 2) | code));
    ord = predict(m, code);
    exp_q.push_back(ord);
  endtask

  task automatic run_to(int ord);
    while (tick_n < ord) do_tick();
  endtask

  task automatic finish_case();
    wr(8'h00);
    ack();
  endtask

  // monitor: pops the expected ordinal whenever the flag rises
  initial begin
    logic prev = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (rst_n && flag && !prev) begin
        if (exp_q.size() == 0) chk("R3/R4 unexpected timeout", tick_n, -1);
        else chk("R3 timeout ordinal", tick_n, exp_q.pop_front());
      end
      prev = flag;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ord;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 cfg", cfg, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst_n_o", rst_out, 1);
    chk("R1 aux", aux, 0);

    // R2 layout, R3 fine resolution, R6 interrupt steering
    arm(0, 5, 0, ord);
    chk("R2 cfg readback", cfg, 8'h14);
    run_to(ord);
    chk("R6 flag", flag, 1);
    chk("R6 irq", irq, 1);
    chk("R6 rst stays high", rst_out, 1);
    chk("R6 cfg kept", cfg, 8'h14);
    finish_case();
    // R9
    chk("R9 flag cleared", flag, 0);
    chk("R9 irq cleared", irq, 0);

    // R3 coarse resolutions, prescaler phase not realigned
    do_tick(); do_tick(); do_tick();
    arm(0, 3, 2, ord);            // 8'h0E: 3 x 1 s
    chk("R2 cfg 0E", cfg, 8'h0E);
    run_to(ord); finish_case();
    arm(0, 2, 1, ord); run_to(ord); finish_case();
    do_tick();
    arm(0, 1, 3, ord); run_to(ord); finish_case();
    arm(0, 31, 0, ord); run_to(ord); finish_case();

    // R4 rewrite restarts
    wr(8'h10);                    // M=4, code 00, no expectation yet
    do_tick(); do_tick(); do_tick();
    chk("R4 no early flag", flag, 0);
    arm(0, 4, 0, ord);
    run_to(ord); finish_case();

    // R5 disabled settings
    wr(8'h03);
    repeat (70) do_tick();
    chk("R5 M=0 quiet", flag, 0);
    wr(8'h00);
    repeat (10) do_tick();
    chk("R5 zero quiet", flag, 0);

    // R7 reset steering
    arm(1, 2, 0, ord);
    chk("R2 cfg 88", cfg, 8'h88);
    run_to(ord);
    chk("R7 flag", flag, 1);
    chk("R7 cfg wiped", cfg, 0);
    chk("R7 aux pulse", aux, 1);
    chk("R7 rst low", rst_out, 0);
    chk("R7 no irq", irq, 0);
    n = 0;
    while (!rst_out && n < 1000) begin
      @(posedge clk); #1; n++;
      if (n == 1) chk("R7 aux one cycle", aux, 0);
    end
    chk("R7 pulse length", n, RST_CYC);
    repeat (10) do_tick();
    chk("R7 no retrigger", rst_out, 1);
    ack();

    // R8 power-down
    wr(8'h14);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk("R8 cfg cleared", cfg, 0);
    wr(8'h04);
    chk("R8 write ignored", cfg, 0);
    @(negedge clk); pwr_fail = 1'b0;
    repeat (10) do_tick();
    chk("R8 no timeout", flag, 0);

    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule